// File: doc/BRIEF.md
# Banked XOR Scatter-Gather Scratchpad

This block is a work-group scratchpad made of four separate 32-bit memory banks. Each bank has its own write port and its own read port. In the first phase, called scatter, the block accepts one item per cycle. An item carries a value, a local index `li` and a group size `ls`. In that same cycle the block writes four copies of the value, one into each bank. Copy `k` is the value arithmetically shifted right by `k` bits. It is stored in bank `k` at address `(li*k) mod ls`.

The phase changes once the `ls`-th item has been stored, which acts as the barrier. In the second phase, called gather, the block emits one result per accepted output cycle, in local-index order. Result `g` is the XOR of bank `k` at address `((ls-g)*k) mod ls` for `k` = 0..3. Each unrolled store and each unrolled load has a bank of its own. No access ever waits on an arbiter, and no access ever stalls.

The modulo needs no divider. The product is at most three times `ls`, so a few conditional subtractions reduce it. The bank address is 10 bits wide.

Top module: `xor_scatter_gather`

## Requirements
- R1: After a synchronous active-high reset, the block is in scatter: `in_ready` is 1, `out_valid` is 0 and the item counter is zero. Bank contents are kept.
- R2: An accepted item writes `value >>> k` to bank `k` at address `(li*k) mod ls`, for all four banks in the same cycle.
- R3: Result `g` on `out_data` equals the XOR, starting from zero, of bank `k` at address `((ls-g)*k) mod ls` for `k` = 0..3.
- R4: No result is offered until all `ls` items of the group have been accepted. In the cycle after the last item is accepted, `out_valid` is 1 and `in_ready` is 0. During scatter, `out_valid` is 0.
- R5: Results come out in local-index order. `out_idx` runs 0, 1, …, `ls-1`, and advances only on `out_valid && out_ready`.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_idx` and `out_data` hold steady.
- R7: In the cycle after result `ls-1` is taken, the block is back in scatter with `in_ready` 1 and `out_valid` 0, ready for a new group.
- R8: When several items write the same address, the item accepted last wins. Bank 0 always writes address 0, so result 0 reads the value of the last item in bank 0.
- R9: A group of size 1 uses address 0 in every bank. Its single result is `v ^ v>>>1 ^ v>>>2 ^ v>>>3`.
- R10: The shift is arithmetic, so a negative value fills its upper bits with ones in banks 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Item offered |
| in_ready | output | 1 | Item accepted this cycle when valid (scatter phase) |
| in_data | input | 32 | Item value, two's complement |
| in_idx | input | 10 | Local index `li` of the item, below `grp_size` |
| grp_size | input | 11 | Group size `ls`, 1 to 1024, constant within a group |
| out_valid | output | 1 | Result offered (gather phase) |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | XOR result for local index `out_idx` |
| out_idx | output | 10 | Local index of the offered result |

## Verification
The store of the last item and the switch into gather happen in the same cycle. The first read must therefore return data written one edge earlier, including the bank 0 address that every item overwrites. The bench provokes this with every group and judges it against a software model of the banks that is updated on each accepted item. It also starts gather with random output stalls, so that a hold and the first read also meet. Groups of size 1, 2, 3, 7, 1024 and random sizes are run, with both random and directed negative values.

// File: rtl/xor_scatter_gather.sv
module xor_scatter_gather #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  parameter int NB    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DW-1:0]            in_data,
  input  logic [$clog2(DEPTH)-1:0] in_idx,
  input  logic [$clog2(DEPTH):0]   grp_size,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DW-1:0]            out_data,
  output logic [$clog2(DEPTH)-1:0] out_idx
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1 + $clog2(NB);

  logic          gath;
  logic [AW-1:0] cnt;
  logic [AW:0]   ls_q;
  logic [AW-1:0] waddr [NB];
  logic [AW-1:0] raddr [NB];
  logic [DW-1:0] wdat  [NB];
  logic [DW-1:0] rdat  [NB];
  logic [AW:0]   dif;
  logic          wr, fill_last, drain_last;

  function automatic logic [AW-1:0] fold(input logic [PW-1:0] p, input logic [AW:0] m);
    logic [PW-1:0] r;
    r = p;
    for (int s = 0; s < NB; s++)
      if (r >= PW'(m)) r = r - PW'(m);
    return r[AW-1:0];
  endfunction

  assign in_ready   = !gath;
  assign out_valid  = gath;
  assign out_idx    = cnt;
  assign wr         = in_valid && !gath;
  assign dif        = ls_q - {1'b0, cnt};
  assign fill_last  = ({1'b0, cnt} + 1'b1) == grp_size;
  assign drain_last = ({1'b0, cnt} + 1'b1) == ls_q;

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      waddr[k] = fold(PW'(in_idx) * PW'(k), grp_size);
      raddr[k] = fold(PW'(dif) * PW'(k), ls_q);
      wdat[k]  = DW'($signed(in_data) >>> k);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk)
      if (wr) mem[waddr[b]] <= wdat[b];
    assign rdat[b] = mem[raddr[b]];
  end

  always_comb begin
    out_data = '0;
    for (int k = 0; k < NB; k++) out_data = out_data ^ rdat[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gath <= 1'b0;
      cnt  <= '0;
      ls_q <= '0;
    end else if (wr) begin
      ls_q <= grp_size;
      if (fill_last) begin
        gath <= 1'b1;
        cnt  <= '0;
      end else cnt <= cnt + 1'b1;
    end else if (gath && out_ready) begin
      if (drain_last) begin
        gath <= 1'b0;
        cnt  <= '0;
      end else cnt <= cnt + 1'b1;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> in_ready && !out_valid && out_idx == '0);

  assert_addr_in_group_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |-> {1'b0, waddr[NB-1]} < grp_size);

  assert_barrier_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && ({1'b0, out_idx} + 1'b1) == grp_size
      |=> out_valid && !in_ready && out_idx == '0);

  assert_in_order_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !drain_last |=> out_valid && out_idx == $past(out_idx) + 1'b1);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_data));

  assert_back_to_scatter_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && drain_last |=> in_ready && !out_valid);
endmodule

// File: tb/xor_scatter_gather_tb.sv
module xor_scatter_gather_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_data, out_data;
  logic [9:0]  in_idx, out_idx;
  logic [10:0] grp_size;

  int checks = 0, failures = 0, cyc = 0;
  int mb [4][1024];

  always #5 clk = ~clk;

  xor_scatter_gather u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_idx(in_idx), .grp_size(grp_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_idx(out_idx));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expect_at(input int ls, input int g);
    int r = 0;
    for (int k = 0; k < 4; k++) r = r ^ mb[k][((ls - g) * k) % ls];
    return r;
  endfunction

  task automatic scatter(input int ls, input bit neg);
    for (int li = 0; li < ls; li++) begin
      @(negedge clk);
      check(!out_valid, "R4", out_valid, 0);
      in_valid = 1'b1;
      in_data  = neg ? (32'h8000_0000 | ($urandom & 32'h00FF_FFF0)) : $urandom;
      in_idx   = 10'(li);
      grp_size = 11'(ls);
      @(posedge clk);
      // R2 model: bank k, address (li*k) mod ls, value >>> k
      for (int k = 0; k < 4; k++) mb[k][(li * k) % ls] = $signed(in_data) >>> k;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && !in_ready && out_idx == 0, "R4", {out_valid, in_ready}, 2'b10);
  endtask

  task automatic gather(input int ls, input bit neg);
    int g = 0;
    bit stalled = 0;
    logic [31:0] pd;
    logic [9:0]  pi;
    while (g < ls) begin
      out_ready = ($urandom % 4) != 0;
      if (stalled) check(out_data == pd && out_idx == pi, "R6", out_data, pd);
      if (out_valid && out_ready) begin
        check(out_idx == 10'(g), "R5", out_idx, g);
        if (ls == 1)
          check(out_data == 32'(expect_at(ls, g)), neg ? "R10" : "R9", out_data, expect_at(ls, g));
        else if (g == 0)
          check(out_data == 32'(expect_at(ls, g)), "R8", out_data, expect_at(ls, g));
        else
          check(out_data == 32'(expect_at(ls, g)), neg ? "R10" : "R2,R3", out_data, expect_at(ls, g));
        g++;
      end
      stalled = out_valid && !out_ready;
      pd = out_data;
      pi = out_idx;
      @(posedge clk);
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(in_ready && !out_valid, "R7", {in_ready, out_valid}, 2'b10);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    in_data = '0; in_idx = '0; grp_size = 11'd1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check(in_ready && !out_valid && out_idx == 0, "R1", {in_ready, out_valid}, 2'b10);

    scatter(1, 1'b0);  gather(1, 1'b0);
    scatter(1, 1'b1);  gather(1, 1'b1);
    scatter(2, 1'b0);  gather(2, 1'b0);
    scatter(3, 1'b1);  gather(3, 1'b1);
    scatter(7, 1'b0);  gather(7, 1'b0);
    for (int n = 0; n < 4; n++) begin
      int ls = 5 + int'($urandom % 60);
      scatter(ls, n[0]);
      gather(ls, n[0]);
    end
    scatter(1024, 1'b0); gather(1024, 1'b0);

    scatter(6, 1'b0);
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk) begin out_ready = 1'b0; rst = 1'b1; end
    @(negedge clk) rst = 1'b0;
    check(in_ready && !out_valid && out_idx == 0, "R1", {in_ready, out_valid}, 2'b10);
    scatter(9, 1'b1); gather(9, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule